// File: doc/BRIEF.md
# Three-Phase Half-Bridge Command Interlock

This block sits between the motor-control timer outputs and the gate-drive enables of three external half-bridges. Each bridge receives a high-side and a low-side command. The block turns them into registered high-side and low-side gate enables. No bridge may ever have both enables on at once. Before one side is allowed on, the other side must have been off for a programmable minimum gap. That gap is added only when the commands themselves leave too little dead time.

The block also handles overlapping commands. When both commands of a bridge are active together, both enables are blanked. If the overlap lasts too long, the bridge is latched off behind a sticky fault flag, which only a clear strobe from the register interface can release. A hard-off strobe per enable requests maximum sink current on a turning-off gate. A mode bit picks when that strobe fires. A global disable input forces every enable off.

The gap length T is set by a 3-bit code through a parameterised step: T = STEP × (code + 1) clock ticks. With the default STEP of 4, T runs from 4 to 32 ticks.

Top module: `hbi_interlock`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all gate enables, sink strobes and fault flags are 0.
- R2: A bridge's gate enable becomes 1 on the clock edge that samples its own command 1 and the opposite command 0. This holds when the opposite enable is already 0 and has been 0 for at least T edges. The enable becomes 0 on the edge that samples its command 0.
- R3: On the edge that samples both commands of a bridge at 1, both of its enables become 0. The two enables of one bridge are never 1 together.
- R4: After one enable of a bridge falls on edge k, the opposite enable rises no earlier than edge k+T. If the opposite command first arrives T or more edges after k, no extra delay is added beyond the normal one-edge latency.
- R5: T = STEP × (code + 1), where code is the 3-bit `cct_code` input (0 to 7) and STEP is a parameter (default 4). The current code is used on every edge.
- R6: When a bridge's commands are sampled both at 1 on more than T consecutive edges, its fault flag is set on the (T+1)-th such edge. While the flag is 1, both enables of that bridge stay 0.
- R7: The fault flag is sticky. It is cleared only on an edge that samples the bridge's `fault_clr` bit at 1 while the overlap condition of R6 is not present. A sustained overlap on the same edge as a clear keeps the flag set.
- R8: With `hoff_mode` = 0, a sink strobe is 1 for exactly one cycle: the T-th cycle after its own enable fell. It is the cycle between edges k+T-1 and k+T when the fall was on edge k. The strobe is cancelled if the enable turns on again before that cycle.
- R9: With `hoff_mode` = 1, a side's sink strobe is 1 for exactly the first cycle in which the complementary enable of the same bridge is 1.
- R10: On the edge that samples `drv_disable` at 1, all six gate enables become 0.
- R11: Each bridge's interlock, gap timing and fault state depend only on that bridge's own commands and clear bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_hi | input | 3 | High-side command per bridge |
| in_lo | input | 3 | Low-side command per bridge |
| drv_disable | input | 1 | Global disable, forces all enables off |
| cct_code | input | 3 | Cross-conduction gap code |
| hoff_mode | input | 1 | Hard-off strobe timing select |
| fault_clr | input | 3 | Per-bridge fault clear strobe |
| gate_hi | output | 3 | High-side gate enable per bridge |
| gate_lo | output | 3 | Low-side gate enable per bridge |
| sink_hi | output | 3 | High-side hard-off sink strobe |
| sink_lo | output | 3 | Low-side hard-off sink strobe |
| fault | output | 3 | Sticky overlap fault flag per bridge |

## Verification
Two things can fall on the same edge: the overlap trip and the fault clear. The bench provokes this by pulsing `fault_clr` while a bridge's commands are still both held active past T edges. It then expects the flag to stay set. It repeats the clear once the overlap has been removed and expects the flag to drop and the enables to resume. A second coincidence is a commutation that ends with zero input dead time while the inserted gap is still counting. There, the bench's timeline model predicts the exact edge on which the delayed enable rises, and the exact cycle of each sink strobe, in both hard-off modes.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  localparam int unsigned CODE_W = 3;

  // Gap length in ticks for a given code.
  function automatic int unsigned cct_ticks(input logic [CODE_W-1:0] code,
                                            input int unsigned step);
    return step * (32'(code) + 32'd1);
  endfunction

  // elapsed counts edges since the fall minus one; the gap is met after T edges.
  function automatic logic gap_met(input int unsigned elapsed,
                                   input int unsigned ticks);
    return (elapsed + 32'd1) >= ticks;
  endfunction

  // Delayed hard-off strobe falls on the T-th off cycle.
  function automatic logic strobe_due(input int unsigned elapsed,
                                      input int unsigned ticks);
    return (elapsed + 32'd1) == ticks;
  endfunction

  // Overlap trip: sustained past the gap length.
  function automatic logic overlap_trip(input int unsigned run,
                                        input int unsigned ticks);
    return run >= ticks;
  endfunction

endpackage

// File: rtl/hbi_off_timer.sv
module hbi_off_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  output logic [CNT_W-1:0] off_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Saturating count of edges since the gate was last seen on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 off_cnt <= CNT_MAX;
    else if (gate)              off_cnt <= '0;
    else if (off_cnt != CNT_MAX) off_cnt <= off_cnt + 1'b1;
  end

endmodule

// File: rtl/hbi_overlap_guard.sv
module hbi_overlap_guard
  import hbi_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        both_on,
  input  logic        clr,
  input  logic [31:0] ticks,
  output logic        trip,
  output logic        fault
);

  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic [CNT_W-1:0] run_cnt;

  assign trip = both_on && overlap_trip(32'(run_cnt), ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_cnt <= '0;
    else if (!both_on)           run_cnt <= '0;
    else if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
  end

  // Set has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fault <= 1'b0;
    else if (trip)  fault <= 1'b1;
    else if (clr)   fault <= 1'b0;
  end

endmodule

// File: rtl/hbi_bridge.sv
module hbi_bridge
  import hbi_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_hi,
  input  logic        cmd_lo,
  input  logic        dis,
  input  logic [31:0] ticks,
  input  logic        hoff_mode,
  input  logic        clr,
  output logic        gate_hi,
  output logic        gate_lo,
  output logic        sink_hi,
  output logic        sink_lo,
  output logic        fault
);

  logic [CNT_W-1:0] off_hi, off_lo;
  logic             prev_hi, prev_lo;
  logic             req_hi, req_lo;
  logic             next_hi, next_lo;
  logic             trip;
  logic             rise_hi, rise_lo;
  logic             late_hi, late_lo;

  hbi_off_timer #(.CNT_W(CNT_W)) u_off_hi (
    .clk(clk), .rst_n(rst_n), .gate(gate_hi), .off_cnt(off_hi));

  hbi_off_timer #(.CNT_W(CNT_W)) u_off_lo (
    .clk(clk), .rst_n(rst_n), .gate(gate_lo), .off_cnt(off_lo));

  hbi_overlap_guard #(.CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .both_on(cmd_hi && cmd_lo), .clr(clr),
    .ticks(ticks), .trip(trip), .fault(fault));

  // Exclusive requests: overlap, disable or fault blank both sides.
  assign req_hi = cmd_hi && !cmd_lo && !dis && !fault;
  assign req_lo = cmd_lo && !cmd_hi && !dis && !fault;

  // A side turns on only once the other has been off long enough.
  assign next_hi = req_hi && !gate_lo && gap_met(32'(off_lo), ticks);
  assign next_lo = req_lo && !gate_hi && gap_met(32'(off_hi), ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      prev_hi <= 1'b0;
      prev_lo <= 1'b0;
    end else begin
      gate_hi <= next_hi;
      gate_lo <= next_lo;
      prev_hi <= gate_hi;
      prev_lo <= gate_lo;
    end
  end

  // Hard-off event wires.
  assign rise_hi = gate_hi && !prev_hi;
  assign rise_lo = gate_lo && !prev_lo;
  assign late_hi = !gate_hi && strobe_due(32'(off_hi), ticks);
  assign late_lo = !gate_lo && strobe_due(32'(off_lo), ticks);

  assign sink_hi = hoff_mode ? rise_lo : late_hi;
  assign sink_lo = hoff_mode ? rise_hi : late_lo;

endmodule

// File: rtl/hbi_interlock.sv
module hbi_interlock
  import hbi_pkg::*;
#(
  parameter int unsigned NB    = 3,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned STEP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     in_hi,
  input  logic [NB-1:0]     in_lo,
  input  logic              drv_disable,
  input  logic [CODE_W-1:0] cct_code,
  input  logic              hoff_mode,
  input  logic [NB-1:0]     fault_clr,
  output logic [NB-1:0]     gate_hi,
  output logic [NB-1:0]     gate_lo,
  output logic [NB-1:0]     sink_hi,
  output logic [NB-1:0]     sink_lo,
  output logic [NB-1:0]     fault
);

  logic [31:0] gap_ticks;

  assign gap_ticks = cct_ticks(cct_code, STEP);

  for (genvar b = 0; b < NB; b++) begin : g_br
    hbi_bridge #(.CNT_W(CNT_W)) u_br (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_hi   (in_hi[b]),
      .cmd_lo   (in_lo[b]),
      .dis      (drv_disable),
      .ticks    (gap_ticks),
      .hoff_mode(hoff_mode),
      .clr      (fault_clr[b]),
      .gate_hi  (gate_hi[b]),
      .gate_lo  (gate_lo[b]),
      .sink_hi  (sink_hi[b]),
      .sink_lo  (sink_lo[b]),
      .fault    (fault[b])
    );
  end

endmodule

// File: rtl/hbi_interlock_chk.sv
module hbi_interlock_chk #(
  parameter int unsigned NB = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] in_hi,
  input logic [NB-1:0] in_lo,
  input logic          drv_disable,
  input logic          hoff_mode,
  input logic [NB-1:0] fault_clr,
  input logic [NB-1:0] gate_hi,
  input logic [NB-1:0] gate_lo,
  input logic [NB-1:0] sink_hi,
  input logic [NB-1:0] fault
);

  AST_DISABLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    drv_disable |=> (gate_hi == '0 && gate_lo == '0)); // R10

  for (genvar b = 0; b < NB; b++) begin : g_chk
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[b] && gate_lo[b])); // R3
    AST_OVERLAP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hi[b] && in_lo[b]) |=> (!gate_hi[b] && !gate_lo[b])); // R3
    AST_OFF_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[b]) |-> !$past(gate_lo[b])); // R4
    AST_FAULT_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      fault[b] |-> (!gate_hi[b] && !gate_lo[b])); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fault[b] && !fault_clr[b]) |=> fault[b]); // R7
    AST_MODE0_QUIET_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!hoff_mode && gate_hi[b]) |-> !sink_hi[b]); // R8
    AST_MODE1_SINK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (hoff_mode && $rose(gate_lo[b])) |-> sink_hi[b]); // R9
  end

endmodule

bind hbi_interlock hbi_interlock_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_hi(in_hi), .in_lo(in_lo),
  .drv_disable(drv_disable), .hoff_mode(hoff_mode), .fault_clr(fault_clr),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .sink_hi(sink_hi), .fault(fault));

// File: tb/hbi_interlock_bench.sv
`timescale 1ns/1ps
module hbi_interlock_bench;

  localparam int NB = 3;
  localparam int STEP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] in_hi = '0, in_lo = '0, fault_clr = '0;
  logic          drv_disable = 1'b0, hoff_mode = 1'b0;
  logic [2:0]    cct_code = 3'd0;
  logic [NB-1:0] gate_hi, gate_lo, sink_hi, sink_lo, fault;

  always #5 clk = ~clk;

  hbi_interlock u_hbi_interlock (
    .clk(clk), .rst_n(rst_n), .in_hi(in_hi), .in_lo(in_lo),
    .drv_disable(drv_disable), .cct_code(cct_code), .hoff_mode(hoff_mode),
    .fault_clr(fault_clr), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .sink_hi(sink_hi), .sink_lo(sink_lo), .fault(fault));

  int checks = 0, fails = 0;
  bit finished = 0;
  string phase = "R1";

  // Timeline reference model: edge index, fall times, overlap runs.
  int edge_n = 0;
  int m_gh[NB], m_gl[NB], fall_h[NB], fall_l[NB], run[NB], m_flt[NB];
  int rose_h[NB], rose_l[NB];

  function automatic int gap_len();
    return STEP * (int'(cct_code) + 1);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_gh[b] = 0; m_gl[b] = 0; fall_h[b] = -1000; fall_l[b] = -1000;
      run[b] = 0; m_flt[b] = 0; rose_h[b] = 0; rose_l[b] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      edge_n = 0;
    end else begin
      int t;
      edge_n++;
      t = gap_len();
      for (int b = 0; b < NB; b++) begin
        bit both, want_h, want_l, nh, nl, trip;
        both   = in_hi[b] && in_lo[b];
        trip   = both && (run[b] >= t);
        want_h = in_hi[b] && !in_lo[b] && !drv_disable && (m_flt[b] == 0);
        want_l = in_lo[b] && !in_hi[b] && !drv_disable && (m_flt[b] == 0);
        nh = want_h && (m_gl[b] == 0) && (edge_n - fall_l[b] >= t);
        nl = want_l && (m_gh[b] == 0) && (edge_n - fall_h[b] >= t);
        if (m_gh[b] == 1 && !nh) fall_h[b] = edge_n;
        if (m_gl[b] == 1 && !nl) fall_l[b] = edge_n;
        rose_h[b] = (nh && m_gh[b] == 0) ? 1 : 0;
        rose_l[b] = (nl && m_gl[b] == 0) ? 1 : 0;
        m_gh[b] = nh; m_gl[b] = nl;
        run[b] = both ? run[b] + 1 : 0;
        if (trip) m_flt[b] = 1;
        else if (fault_clr[b]) m_flt[b] = 0;
      end
    end
  end

  task automatic chk(input string what, input logic [NB-1:0] act,
                     input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b at edge %0d", phase, what, act, exp, edge_n);
    end
  endtask

  task automatic compare_all();
    logic [NB-1:0] e_gh, e_gl, e_sh, e_sl, e_f;
    int t;
    t = gap_len();
    for (int b = 0; b < NB; b++) begin
      e_gh[b] = m_gh[b][0];
      e_gl[b] = m_gl[b][0];
      e_f[b]  = m_flt[b][0];
      if (hoff_mode) begin
        e_sh[b] = rose_l[b][0];
        e_sl[b] = rose_h[b][0];
      end else begin
        e_sh[b] = (m_gh[b] == 0) && (edge_n - fall_h[b] == t - 1);
        e_sl[b] = (m_gl[b] == 0) && (edge_n - fall_l[b] == t - 1);
      end
    end
    chk("gate_hi", gate_hi, e_gh);
    chk("gate_lo", gate_lo, e_gl);
    chk("sink_hi", sink_hi, e_sh);
    chk("sink_lo", sink_lo, e_sl);
    chk("fault",   fault,   e_f);
  endtask

  task automatic run_cycles(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("gate_hi", gate_hi, '0); chk("gate_lo", gate_lo, '0);
    chk("fault", fault, '0);
    rst_n = 1'b1;
    run_cycles(2);
    // R2: plain on/off following on bridge 0 and low side of bridge 1
    phase = "R2";
    in_lo = 3'b010; run_cycles(3);
    in_hi = 3'b001; run_cycles(3);
    in_hi = 3'b000; in_lo = 3'b000; run_cycles(8);
    // R4: zero dead time commutation inserts the gap
    phase = "R4";
    in_lo = 3'b001; run_cycles(6);
    in_lo = 3'b000; in_hi = 3'b001; run_cycles(8);
    // R4: long input dead time, no extra delay
    in_hi = 3'b000; run_cycles(6);
    in_lo = 3'b001; run_cycles(4);
    // R5: larger code lengthens the gap
    phase = "R5";
    cct_code = 3'd2;
    in_lo = 3'b000; in_hi = 3'b001; run_cycles(16);
    in_hi = 3'b000; in_lo = 3'b001; run_cycles(16);
    in_lo = 3'b000; cct_code = 3'd0; run_cycles(6);
    // R3: short overlap only blanks
    phase = "R3";
    in_hi = 3'b100; run_cycles(6);
    in_lo = 3'b100; run_cycles(3);
    in_lo = 3'b000; run_cycles(6);
    // R6: sustained overlap latches the fault
    phase = "R6";
    in_lo = 3'b100; run_cycles(8);
    // R7: clear during overlap is ignored, clear after removal works
    phase = "R7";
    fault_clr = 3'b100; run_cycles(1);
    fault_clr = 3'b000; run_cycles(2);
    in_hi = 3'b000; in_lo = 3'b000; run_cycles(3);
    chk("fault R7 held", fault, 3'b100);
    fault_clr = 3'b100; run_cycles(1);
    fault_clr = 3'b000; run_cycles(2);
    chk("fault R7 cleared", fault, 3'b000);
    in_hi = 3'b100; run_cycles(4);
    // R8: delayed hard-off in mode 0
    phase = "R8";
    hoff_mode = 1'b0;
    in_hi = 3'b000; run_cycles(8);
    in_lo = 3'b001; run_cycles(5);
    in_lo = 3'b000; run_cycles(2);
    in_lo = 3'b001; run_cycles(8);
    // R9: complementary-rise hard-off in mode 1
    phase = "R9";
    hoff_mode = 1'b1;
    in_lo = 3'b000; in_hi = 3'b001; run_cycles(8);
    in_hi = 3'b000; in_lo = 3'b001; run_cycles(8);
    // R10: global disable
    phase = "R10";
    in_hi = 3'b110; in_lo = 3'b001; run_cycles(8);
    drv_disable = 1'b1; run_cycles(3);
    chk("gate_hi R10", gate_hi, 3'b000); chk("gate_lo R10", gate_lo, 3'b000);
    drv_disable = 1'b0; run_cycles(8);
    // R11: bridges independent, fault on one only
    phase = "R11";
    hoff_mode = 1'b0;
    in_hi = 3'b011; in_lo = 3'b010; run_cycles(8);
    chk("fault R11", fault, 3'b010);
    in_hi = 3'b001; in_lo = 3'b100; fault_clr = 3'b111; run_cycles(1);
    fault_clr = 3'b000; run_cycles(10);
    in_hi = '0; in_lo = '0; run_cycles(6);
    finish_run();
  end

endmodule